// File: doc/BRIEF.md
# Master-Aware Policy Register Bank

This block is a small bank of 8-bit control and status registers that sits behind an AHB-Lite slave port. Each transfer carries one register on the 8-bit data bus. A transfer is always zero-wait with an OKAY response. Each register follows a fixed access policy:

- plain read-write storage,
- a constant that can only be read,
- a pending-event register whose bits hardware sets and software clears by writing ones.

One register is shared between two bus masters. The transfer's master identifier decides, on every write, whether the write lands. A write from the test master updates it. A write from the host master, or from any other master, leaves it unchanged.

Eight event lines feed the pending register. For each line, a bit in an event-configuration register selects one of two detection modes:

- rising-edge detection, where a bit is set once per edge,
- level detection, where a bit is set on every cycle the line is high.

A global lock input, separate from the bus protocol, can veto any write while it is in its data phase. The control register drives a force-off output, and the surrounding logic also sees the whole control byte, the shared byte and the pending bits.

Top module: `policy_regbank`

## Requirements
- R1: After reset the registers read 0x0C (offset 0x00, control), 0x00 (0x04, event configuration), 0x00 (0x08, pending events), 0xA5 (0x0C, identity) and 0x00 (0x14, shared). The outputs are then force_off=0, ctrl_q=0x0C, shared_q=0x00 and evt_pend=0x00.
- R2: A transfer is taken in the cycle where hsel and htrans[1] are both high. Its write data is sampled in the following cycle (the data phase) and committed at the clock edge that ends it. A cycle with hsel low or htrans[1] low starts no transfer. hready is always 1 and hresp always 0. hrdata is 0x00 in every cycle that is not the data phase of a read.
- R3: Control (0x00) and event configuration (0x04) are read-write: a read returns the last accepted write, for any data value. From the edge that commits a write, ctrl_q shows the control byte and force_off shows its bit 0.
- R4: Identity (0x0C) is read-only: it reads 0xA5 whatever has been written to it.
- R5: Shared (0x14) takes a write only when that transfer's hmaster equals the test master ID 2. Writes from the host master ID 1, or from any other ID, leave it and shared_q unchanged.
- R6: Pending events (0x08) is write-one-to-clear: a 1 in the write data clears that bit, and a 0 leaves it unchanged. evt_pend shows the register.
- R7: Event line i sets pending bit i at a clock edge. If configuration bit i is 0, the bit is set when the line is high and was low at the previous edge. If configuration bit i is 1, the bit is set at every edge where the line is high.
- R8: When an event detection and a write-one clear hit the same pending bit at the same edge, the bit ends up set.
- R9: When wr_lock is high during a write's data phase, that write is discarded for every register, including pending-bit clears.
- R10: Reads of any offset other than the five above return 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsel | input | 1 | Slave select |
| haddr | input | 8 | Byte address, sampled in the address phase |
| htrans | input | 2 | Transfer type; bit 1 marks an active transfer |
| hwrite | input | 1 | 1 = write, 0 = read |
| hmaster | input | 4 | Identifier of the master issuing the transfer |
| hwdata | input | 8 | Write data, data phase |
| wr_lock | input | 1 | Global write veto, sampled in the data phase |
| evt_in | input | 8 | Hardware event lines |
| hrdata | output | 8 | Read data, data phase |
| hready | output | 1 | Transfer done, tied high |
| hresp | output | 1 | Response, tied OKAY (0) |
| force_off | output | 1 | Bit 0 of the control register |
| ctrl_q | output | 8 | Control register contents |
| shared_q | output | 8 | Shared register contents |
| evt_pend | output | 8 | Pending event bits |

## Verification
The hardest case to reach from the ports is an event detection landing on exactly the same clock edge that commits a write-one clear of the same bit. A close second is a clear issued while a level-mode line is still high. The bench's bus task can change the event lines at the same moment it drives the write data, so a rising edge is placed precisely in the clear's data phase. Further directed steps hold lines high across clears in both detection modes and raise the lock in the data phase only. A seeded random mix of addresses, data, master IDs and lock settings then runs against a bench-side register model.

// File: rtl/prb_pkg.sv
// Package: shared constants, register selectors, field policy kinds and the
// address decoder for the master-aware policy register bank.
// Assumes one register per 8-bit data beat, byte addresses compared in full.
package prb_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 8;
    localparam int N_EVT  = DATA_W;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_EVCFG  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_EVPEND = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_IDENT  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_SHARED = 8'h14;

    typedef enum logic [2:0] {
        SEL_NONE   = 3'd0,
        SEL_CTRL   = 3'd1,
        SEL_EVCFG  = 3'd2,
        SEL_EVPEND = 3'd3,
        SEL_IDENT  = 3'd4,
        SEL_SHARED = 3'd5
    } regsel_e;

    typedef enum logic [0:0] {
        POL_RW  = 1'b0,
        POL_W1C = 1'b1
    } field_pol_e;

    // Map a full byte address to a register selector; unmapped gives SEL_NONE.
    function automatic regsel_e addr_to_sel(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_CTRL:   return SEL_CTRL;
            OFS_EVCFG:  return SEL_EVCFG;
            OFS_EVPEND: return SEL_EVPEND;
            OFS_IDENT:  return SEL_IDENT;
            OFS_SHARED: return SEL_SHARED;
            default:    return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/prb_ahb_front.sv
// Module: AHB-Lite address-phase capture.
// Latches the decoded register, direction and master ID of a transfer when
// hsel and htrans[1] are high. In the data phase it produces a write commit
// strobe gated by the global lock, and a read-active flag.
// Assumes zero-wait, single-beat transfers (hready tied high at the top).
module prb_ahb_front
    import prb_pkg::*;
#(
    parameter int MST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsel,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [MST_W-1:0]  hmaster,
    input  logic              wr_lock,
    output logic              dp_wr,
    output logic              dp_rd,
    output regsel_e           dp_sel,
    output logic [MST_W-1:0]  dp_master
);

    logic             take;
    logic             valid_q;
    logic             write_q;
    regsel_e          sel_q;
    logic [MST_W-1:0] master_q;
    logic             trans_unused;

    // Transfer start: selected and active (NONSEQ or SEQ)
    assign take         = hsel & htrans[1];
    assign trans_unused = htrans[0];

    // Capture the address-phase control for use in the data phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            write_q  <= 1'b0;
            sel_q    <= SEL_NONE;
            master_q <= '0;
        end else begin
            valid_q  <= take;
            write_q  <= hwrite;
            sel_q    <= addr_to_sel(haddr);
            master_q <= hmaster;
        end
    end

    // Data-phase strobes; the lock vetoes the write commit
    assign dp_wr     = valid_q & write_q & ~wr_lock;
    assign dp_rd     = valid_q & ~write_q;
    assign dp_sel    = sel_q;
    assign dp_master = master_q;

endmodule

// File: rtl/prb_evt_detect.sv
// Module: per-line event detector.
// Each line has its own mode bit: 0 gives a one-cycle hit on a rising edge,
// 1 gives a hit on every cycle the line is high.
// Assumes event lines are already synchronous to clk.
module prb_evt_detect #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_in,
    input  logic [N-1:0] mode,
    output logic [N-1:0] hit
);

    for (genvar i = 0; i < N; i++) begin : g_line
        logic prev_q;

        // Remember the line's previous sampled level for edge detection
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= evt_in[i];
        end

        // Level mode passes the line; edge mode passes low-to-high only
        assign hit[i] = mode[i] ? evt_in[i] : (evt_in[i] & ~prev_q);
    end

endmodule

// File: rtl/prb_reg8.sv
// Module: one register of W bits with a selectable access policy.
// POL_RW: a write loads the data. POL_W1C: a write clears the bits that are
// 1 in the data, and hardware set requests win over a clear in the same cycle.
// Assumes we is a single-cycle commit strobe.
module prb_reg8
    import prb_pkg::*;
#(
    parameter int         W      = 8,
    parameter field_pol_e POLICY = POL_RW,
    parameter logic [W-1:0] RST  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_set,
    output logic [W-1:0] q
);

    if (POLICY == POL_W1C) begin : g_w1c
        logic [W-1:0] clr;

        // Clear mask applies only on an accepted write
        assign clr = we ? wdata : '0;

        // Clear the written ones, then OR in hardware sets so sets win
        always_ff @(posedge clk) begin
            if (!rst_n) q <= RST;
            else        q <= (q & ~clr) | hw_set;
        end
    end else begin : g_rw
        logic set_unused;
        assign set_unused = |hw_set;

        // Load the written value on an accepted write
        always_ff @(posedge clk) begin
            if (!rst_n)  q <= RST;
            else if (we) q <= wdata;
        end
    end

endmodule

// File: rtl/prb_regfile.sv
// Module: register storage, per-register write enables and the read mux.
// Holds control and event configuration (read-write), pending events
// (write-one-to-clear), a constant identity, and the shared register, which
// only the test master may write.
// Assumes dp_wr already carries the lock veto.
module prb_regfile
    import prb_pkg::*;
#(
    parameter int                MST_W      = 4,
    parameter logic [MST_W-1:0]  TEST_ID    = 4'd2,
    parameter logic [DATA_W-1:0] CTRL_RST   = 8'h0C,
    parameter logic [DATA_W-1:0] SHARED_RST = 8'h00,
    parameter logic [DATA_W-1:0] IDENT_VAL  = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dp_wr,
    input  logic              dp_rd,
    input  regsel_e           dp_sel,
    input  logic [MST_W-1:0]  dp_master,
    input  logic [DATA_W-1:0] wdata,
    input  logic [N_EVT-1:0]  evt_hit,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] cfg_q,
    output logic [N_EVT-1:0]  pend_q,
    output logic [DATA_W-1:0] shared_q,
    output logic [DATA_W-1:0] rdata
);

    logic we_ctrl;
    logic we_cfg;
    logic we_pend;
    logic we_shared;

    // Per-register commit enables; the shared one also needs the test master
    assign we_ctrl   = dp_wr && (dp_sel == SEL_CTRL);
    assign we_cfg    = dp_wr && (dp_sel == SEL_EVCFG);
    assign we_pend   = dp_wr && (dp_sel == SEL_EVPEND);
    assign we_shared = dp_wr && (dp_sel == SEL_SHARED) && (dp_master == TEST_ID);

    prb_reg8 #(.W(DATA_W), .POLICY(POL_RW), .RST(CTRL_RST)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .we(we_ctrl), .wdata(wdata),
        .hw_set('0), .q(ctrl_q)
    );

    prb_reg8 #(.W(DATA_W), .POLICY(POL_RW), .RST('0)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(we_cfg), .wdata(wdata),
        .hw_set('0), .q(cfg_q)
    );

    prb_reg8 #(.W(N_EVT), .POLICY(POL_W1C), .RST('0)) u_pend (
        .clk(clk), .rst_n(rst_n), .we(we_pend), .wdata(wdata[N_EVT-1:0]),
        .hw_set(evt_hit), .q(pend_q)
    );

    prb_reg8 #(.W(DATA_W), .POLICY(POL_RW), .RST(SHARED_RST)) u_shared (
        .clk(clk), .rst_n(rst_n), .we(we_shared), .wdata(wdata),
        .hw_set('0), .q(shared_q)
    );

    // Read mux: data only in a read data phase, zero for unmapped offsets
    always_comb begin
        rdata = '0;
        if (dp_rd) begin
            case (dp_sel)
                SEL_CTRL:   rdata = ctrl_q;
                SEL_EVCFG:  rdata = cfg_q;
                SEL_EVPEND: rdata = pend_q;
                SEL_IDENT:  rdata = IDENT_VAL;
                SEL_SHARED: rdata = shared_q;
                default:    rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/policy_regbank.sv
// Module: top of the master-aware policy register bank.
// AHB-Lite slave, zero-wait and always OKAY, in front of a small register
// file with per-register access policies and hardware event capture.
// Assumes single-beat transfers and inputs synchronous to clk.
module policy_regbank
    import prb_pkg::*;
#(
    parameter int                MST_W      = 4,
    parameter logic [MST_W-1:0]  TEST_ID    = 4'd2,
    parameter logic [DATA_W-1:0] CTRL_RST   = 8'h0C,
    parameter logic [DATA_W-1:0] SHARED_RST = 8'h00,
    parameter logic [DATA_W-1:0] IDENT_VAL  = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsel,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [MST_W-1:0]  hmaster,
    input  logic [DATA_W-1:0] hwdata,
    input  logic              wr_lock,
    input  logic [N_EVT-1:0]  evt_in,
    output logic [DATA_W-1:0] hrdata,
    output logic              hready,
    output logic              hresp,
    output logic              force_off,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] shared_q,
    output logic [N_EVT-1:0]  evt_pend
);

    logic              dp_wr;
    logic              dp_rd;
    regsel_e           dp_sel;
    logic [MST_W-1:0]  dp_master;
    logic [DATA_W-1:0] cfg_q;
    logic [N_EVT-1:0]  evt_hit;

    prb_ahb_front #(.MST_W(MST_W)) u_front (
        .clk(clk), .rst_n(rst_n), .hsel(hsel), .htrans(htrans),
        .hwrite(hwrite), .haddr(haddr), .hmaster(hmaster),
        .wr_lock(wr_lock), .dp_wr(dp_wr), .dp_rd(dp_rd),
        .dp_sel(dp_sel), .dp_master(dp_master)
    );

    prb_evt_detect #(.N(N_EVT)) u_evt (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
        .mode(cfg_q[N_EVT-1:0]), .hit(evt_hit)
    );

    prb_regfile #(
        .MST_W(MST_W), .TEST_ID(TEST_ID), .CTRL_RST(CTRL_RST),
        .SHARED_RST(SHARED_RST), .IDENT_VAL(IDENT_VAL)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .dp_wr(dp_wr), .dp_rd(dp_rd),
        .dp_sel(dp_sel), .dp_master(dp_master), .wdata(hwdata),
        .evt_hit(evt_hit), .ctrl_q(ctrl_q), .cfg_q(cfg_q),
        .pend_q(evt_pend), .shared_q(shared_q), .rdata(hrdata)
    );

    // Zero-wait, always-OKAY slave response
    assign hready    = 1'b1;
    assign hresp     = 1'b0;
    assign force_off = ctrl_q[0];

endmodule

// File: rtl/prb_checker.sv
// Module: property checker for policy_regbank, bound to every instance.
// Tracks the bus address phase on its own and checks port behaviour over time.
module prb_checker
    import prb_pkg::*;
#(
    parameter int                MST_W      = 4,
    parameter logic [MST_W-1:0]  TEST_ID    = 4'd2,
    parameter logic [DATA_W-1:0] CTRL_RST   = 8'h0C,
    parameter logic [DATA_W-1:0] SHARED_RST = 8'h00
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hsel,
    input logic [ADDR_W-1:0] haddr,
    input logic [1:0]        htrans,
    input logic              hwrite,
    input logic [MST_W-1:0]  hmaster,
    input logic [DATA_W-1:0] hwdata,
    input logic              wr_lock,
    input logic [N_EVT-1:0]  evt_in,
    input logic [DATA_W-1:0] hrdata,
    input logic              hready,
    input logic              hresp,
    input logic [DATA_W-1:0] ctrl_q,
    input logic [DATA_W-1:0] shared_q,
    input logic [N_EVT-1:0]  evt_pend
);

    logic              ap_q;
    logic              wr_q;
    logic [ADDR_W-1:0] a_q;
    logic [MST_W-1:0]  m_q;
    logic              ctrl_commit;
    logic              pend_commit;

    // Independent record of the previous cycle's address phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ap_q <= 1'b0;
            wr_q <= 1'b0;
            a_q  <= '0;
            m_q  <= '0;
        end else begin
            ap_q <= hsel && htrans[1];
            wr_q <= hwrite;
            a_q  <= haddr;
            m_q  <= hmaster;
        end
    end

    assign ctrl_commit = ap_q && wr_q && (a_q == OFS_CTRL) && !wr_lock;
    assign pend_commit = ap_q && wr_q && (a_q == OFS_EVPEND) && !wr_lock;

    p_reset_vals_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (ctrl_q == CTRL_RST) && (shared_q == SHARED_RST));

    p_zero_wait_okay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hready && !hresp);

    p_ctrl_loads_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_commit |=> (ctrl_q == $past(hwdata)));

    p_ctrl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_commit |=> $stable(ctrl_q));

    p_shared_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_q && wr_q && (a_q == OFS_SHARED) && (m_q != TEST_ID)) |=> $stable(shared_q));

    p_w1c_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_commit && (evt_in == '0)) |=> ((evt_pend & $past(hwdata[N_EVT-1:0])) == '0));

    p_no_spurious_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_in == '0) |=> ((evt_pend & ~$past(evt_pend)) == '0));

    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_q && !wr_q && (addr_to_sel(a_q) == SEL_NONE)) |-> (hrdata == '0));

endmodule

bind policy_regbank prb_checker #(
    .MST_W(MST_W), .TEST_ID(TEST_ID), .CTRL_RST(CTRL_RST), .SHARED_RST(SHARED_RST)
) u_prb_checker (
    .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hmaster(hmaster), .hwdata(hwdata), .wr_lock(wr_lock),
    .evt_in(evt_in), .hrdata(hrdata), .hready(hready), .hresp(hresp),
    .ctrl_q(ctrl_q), .shared_q(shared_q), .evt_pend(evt_pend)
);

// File: tb/policy_regbank_bench.sv
// Bench: directed corner cases, then seeded random bus traffic checked
// against a register model written from the requirements.
module policy_regbank_bench;

    localparam logic [3:0] HOST_M  = 4'd1;
    localparam logic [3:0] TEST_M  = 4'd2;
    localparam logic [3:0] OTHER_M = 4'd3;
    localparam logic [7:0] IDENT   = 8'hA5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsel = 1'b0;
    logic [7:0] haddr = '0;
    logic [1:0] htrans = '0;
    logic       hwrite = 1'b0;
    logic [3:0] hmaster = '0;
    logic [7:0] hwdata = '0;
    logic       wr_lock = 1'b0;
    logic [7:0] evt_in = '0;
    logic [7:0] hrdata;
    logic       hready;
    logic       hresp;
    logic       force_off;
    logic [7:0] ctrl_q;
    logic [7:0] shared_q;
    logic [7:0] evt_pend;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] m_ctrl = 8'h0C, m_cfg = 8'h00, m_pend = 8'h00, m_shared = 8'h00;
    logic [7:0] rd;

    always #5 clk = ~clk;

    policy_regbank u_policy_regbank (
        .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
        .hwrite(hwrite), .hmaster(hmaster), .hwdata(hwdata), .wr_lock(wr_lock),
        .evt_in(evt_in), .hrdata(hrdata), .hready(hready), .hresp(hresp),
        .force_off(force_off), .ctrl_q(ctrl_q), .shared_q(shared_q),
        .evt_pend(evt_pend)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // One bus transfer: address phase, then data phase with lock and event lines
    task automatic bus(input logic sel, input logic [1:0] tr, input logic wr,
                       input logic [7:0] a, input logic [7:0] d, input logic [3:0] m,
                       input logic lk, input logic [7:0] ev_dp, output logic [7:0] r);
        @(negedge clk);
        wr_lock = 1'b0;
        hsel = sel; htrans = tr; hwrite = wr; haddr = a; hmaster = m;
        @(negedge clk);
        hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0; haddr = '0;
        hwdata = d; wr_lock = lk; evt_in = ev_dp;
        #1 r = hrdata;
    endtask

    function automatic logic [7:0] model_read(input logic [7:0] a);
        case (a)
            8'h00:   return m_ctrl;
            8'h04:   return m_cfg;
            8'h08:   return m_pend;
            8'h0C:   return IDENT;
            8'h14:   return m_shared;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h00, 8'h04: return "R3";
            8'h08:        return "R6";
            8'h0C:        return "R4";
            8'h14:        return "R5";
            default:      return "R10";
        endcase
    endfunction

    task automatic do_write(input logic [7:0] a, input logic [7:0] d,
                            input logic [3:0] m, input logic lk);
        logic [7:0] r;
        bus(1'b1, 2'b10, 1'b1, a, d, m, lk, evt_in, r);
        if (!lk) begin
            case (a)
                8'h00: m_ctrl = d;
                8'h04: m_cfg = d;
                8'h08: m_pend = m_pend & ~d;
                8'h14: if (m == TEST_M) m_shared = d;
                default: ;
            endcase
        end
    endtask

    task automatic do_read(input logic [7:0] a, output logic [7:0] r);
        bus(1'b1, 2'b10, 1'b0, a, 8'h00, HOST_M, 1'b0, evt_in, r);
    endtask

    task automatic set_evt(input logic [7:0] v);
        @(negedge clk);
        evt_in = v;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired before the run completed");
        finish_run();
    end

    initial begin
        int unsigned seed_init;
        logic [7:0] tmp;
        seed_init = $urandom(32'h5EED_0042);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values at the bus and at the outputs
        do_read(8'h00, rd); chk("R1 ctrl", rd, 8'h0C);
        do_read(8'h04, rd); chk("R1 cfg", rd, 8'h00);
        do_read(8'h08, rd); chk("R1 pend", rd, 8'h00);
        do_read(8'h0C, rd); chk("R1 ident", rd, IDENT);
        do_read(8'h14, rd); chk("R1 shared", rd, 8'h00);
        chk("R1 force_off", {7'd0, force_off}, 8'h00);
        chk("R1 ctrl_q", ctrl_q, 8'h0C);
        chk("R1 shared_q", shared_q, 8'h00);
        chk("R1 evt_pend", evt_pend, 8'h00);
        chk("R2 hready/hresp", {6'd0, hready, hresp}, 8'h02);

        // R2: deselected or IDLE/BUSY cycles start no transfer
        bus(1'b0, 2'b10, 1'b1, 8'h00, 8'hFF, TEST_M, 1'b0, evt_in, rd);
        bus(1'b1, 2'b01, 1'b1, 8'h00, 8'hFF, TEST_M, 1'b0, evt_in, rd);
        do_read(8'h00, rd); chk("R2 ignored writes", rd, 8'h0C);
        bus(1'b1, 2'b00, 1'b0, 8'h0C, 8'h00, HOST_M, 1'b0, evt_in, rd);
        chk("R2 hrdata outside read", rd, 8'h00);

        // R3: read-write registers and the control outputs
        do_write(8'h00, 8'h5B, HOST_M, 1'b0);
        do_read(8'h00, rd); chk("R3 ctrl", rd, 8'h5B);
        chk("R3 force_off", {7'd0, force_off}, 8'h01);
        chk("R3 ctrl_q", ctrl_q, 8'h5B);
        do_write(8'h04, 8'hC3, OTHER_M, 1'b0);
        do_read(8'h04, rd); chk("R3 cfg", rd, 8'hC3);
        do_write(8'h00, 8'h00, TEST_M, 1'b0);
        do_read(8'h00, rd); chk("R3 force_off low", {7'd0, force_off}, 8'h00);

        // R4: identity is constant
        do_write(8'h0C, 8'h00, TEST_M, 1'b0);
        do_read(8'h0C, rd); chk("R4 ident after write", rd, IDENT);

        // R5: shared register follows the master ID
        do_write(8'h14, 8'h77, HOST_M, 1'b0);
        do_read(8'h14, rd); chk("R5 host ignored", rd, 8'h00);
        chk("R5 shared_q host", shared_q, 8'h00);
        do_write(8'h14, 8'h3C, TEST_M, 1'b0);
        do_read(8'h14, rd); chk("R5 test accepted", rd, 8'h3C);
        do_write(8'h14, 8'h99, OTHER_M, 1'b0);
        do_read(8'h14, rd); chk("R5 other ignored", rd, 8'h3C);
        chk("R5 shared_q", shared_q, 8'h3C);

        // R7/R6: bit1 in level mode, the rest in edge mode
        do_write(8'h04, 8'h02, HOST_M, 1'b0);
        set_evt(8'h01);
        do_read(8'h08, rd); chk("R7 edge sets", rd, 8'h01);
        do_write(8'h08, 8'h01, HOST_M, 1'b0);
        do_read(8'h08, rd); chk("R7 edge held no reset", rd, 8'h00);
        set_evt(8'h03);
        do_read(8'h08, rd); chk("R7 level sets", rd, 8'h02);
        do_write(8'h08, 8'h02, HOST_M, 1'b0);
        do_read(8'h08, rd); chk("R7 level re-sets", rd, 8'h02);
        set_evt(8'h00);
        do_write(8'h08, 8'h02, HOST_M, 1'b0);
        do_read(8'h08, rd); chk("R6 clear", rd, 8'h00);
        set_evt(8'h10);
        set_evt(8'h00);
        do_write(8'h08, 8'h00, HOST_M, 1'b0);
        do_read(8'h08, rd); chk("R6 zero keeps", rd, 8'h10);
        do_write(8'h08, 8'hEF, HOST_M, 1'b0);
        do_read(8'h08, rd); chk("R6 other ones keep", rd, 8'h10);
        chk("R6 evt_pend", evt_pend, 8'h10);

        // R8: rising edge lands on the clear's commit edge
        bus(1'b1, 2'b10, 1'b1, 8'h08, 8'h10, HOST_M, 1'b0, 8'h10, rd);
        do_read(8'h08, rd); chk("R8 set wins", rd, 8'h10);
        do_write(8'h08, 8'h10, HOST_M, 1'b0);
        do_read(8'h08, rd); chk("R8 later clear", rd, 8'h00);
        set_evt(8'h00);

        // R9: lock in the data phase vetoes writes
        do_write(8'h00, 8'hAA, TEST_M, 1'b1);
        do_read(8'h00, rd); chk("R9 ctrl locked", rd, 8'h00);
        set_evt(8'h20);
        set_evt(8'h00);
        do_write(8'h08, 8'h20, HOST_M, 1'b1);
        do_read(8'h08, rd); chk("R9 clear locked", rd, 8'h20);
        do_write(8'h08, 8'h20, HOST_M, 1'b0);
        do_read(8'h08, rd); chk("R9 clear unlocked", rd, 8'h00);

        // R10: unmapped offsets
        do_write(8'h10, 8'hFF, TEST_M, 1'b0);
        do_read(8'h10, rd); chk("R10 unmapped 10", rd, 8'h00);
        do_read(8'h01, rd); chk("R10 unmapped 01", rd, 8'h00);
        do_read(8'hFF, rd); chk("R10 unmapped FF", rd, 8'h00);
        do_read(8'h00, rd); chk("R10 ctrl untouched", rd, 8'h00);

        // Seed pending bits for the random phase (edge mode on all lines)
        do_write(8'h04, 8'h00, HOST_M, 1'b0);
        set_evt(8'hFF);
        set_evt(8'h00);
        m_pend = 8'hFF;
        do_read(8'h08, rd); chk("R7 all lines", rd, 8'hFF);

        // Random traffic with event lines held low
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a, a2, d;
            logic [3:0] m;
            logic       lk;
            case ($urandom % 7)
                0: a = 8'h00;
                1: a = 8'h04;
                2: a = 8'h08;
                3: a = 8'h0C;
                4, 5: a = 8'h14;
                default: a = 8'($urandom);
            endcase
            d = 8'($urandom);
            case ($urandom % 4)
                0: m = HOST_M;
                1: m = TEST_M;
                2: m = OTHER_M;
                default: m = 4'($urandom);
            endcase
            lk = (($urandom % 8) == 0);
            do_write(a, d, m, lk);
            a2 = (($urandom % 2) == 0) ? a : 8'($urandom % 6) << 2;
            do_read(a2, tmp);
            chk(tag_of(a2), tmp, model_read(a2));
            chk("R3 ctrl_q", ctrl_q, m_ctrl);
            chk("R3 force_off", {7'd0, force_off}, {7'd0, m_ctrl[0]});
            chk("R5 shared_q", shared_q, m_shared);
            chk("R6 evt_pend", evt_pend, m_pend);
        end

        finish_run();
    end

endmodule